// File: doc/BRIEF.md
# Preemptible Burst Read Engine

This block is a bus master that copies a block of 32-bit words from an external bus into a local buffer memory. Software-side logic gives it a start address and a byte count. The engine then requests the bus and, once granted, issues one address cycle followed by a run of data phases. It keeps going until the block is finished, until single-read rules allow only one phase, or until the grant is withdrawn after the latency timer has run out. When a burst ends early, the engine drops its request for one cycle and then arbitrates again. It resumes at the first word that has not yet been stored.

The remaining count and the next address change only when a data phase actually completes. A burst that is cut short therefore never leaves the engine with a stale or skipped word. Register reads and writes that other masters make through the target port are served on a completely separate path. They can arrive at any time, including in the cycle right after a preemption, and they never touch the transfer state.

Top module: `bm_burst_reader`

## Requirements
- R1: After reset, busy, done, bus_req, bus_adv, bus_irdy and tgt_ack are all low.
- R2: A req_valid seen while idle with a non-zero req_bytes raises busy in the next cycle, and bus_req then stays high until a grant is seen. A req_valid that arrives while busy is ignored.
- R3: A grant seen while requesting gives exactly one address cycle. In that cycle bus_adv and bus_frame are high and bus_addr is the first word not yet stored: the start address for the first burst, or the resume address after it. Data phases (bus_irdy) follow in the next cycle.
- R4: A data phase completes only in a cycle where both bus_irdy and bus_trdy are high. Only then is bus_rdata stored at buffer word bus_addr[MIW+1:2], the address advanced by 4 and the count reduced by 4. In a stalled cycle, bus_addr is held.
- R5: The latency timer is loaded from cfg_lat_timer in the address cycle and counts down once per data cycle until it reaches zero. The burst continues while the grant is high. Once the grant is low and the timer is zero, the current phase is the last. With bus_trdy high every cycle and the grant withdrawn, a burst therefore carries min(cfg_lat_timer+1, remaining words) phases.
- R6: After a burst whose last phase leaves words outstanding, bus_req is low for exactly one cycle. The engine then requests again and resumes at the next address.
- R7: With cfg_single_read=1 or cfg_lat_timer=0, every burst carries exactly one data phase.
- R8: A target access is acknowledged with tgt_ack in the cycle after tgt_valid. When tgt_addr's top bit is 0, the access goes to scratch register tgt_addr[1:0]: a write stores the word and a read returns it. When the top bit is 1, the access reads buffer word tgt_addr[MIW-1:0]. No target access, at any moment, changes the words or addresses of a transfer.
- R9: done is high for one cycle, in the cycle after the final phase completes, and busy is low in that cycle. A request with a zero count gives done in the next cycle and never raises bus_req.
- R10: bus_last is high in the final data phase of the block. bus_frame is high in the address cycle and in every data phase except the last one of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lat_timer | input | LTW | Latency timer reload value; 0 forces single reads |
| cfg_single_read | input | 1 | Forces one data phase per burst |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_addr | input | AW | Start byte address, word aligned |
| req_bytes | input | CW | Byte count, multiple of 4 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_adv | output | 1 | Address cycle |
| bus_frame | output | 1 | Frame: address cycle and non-final data phases |
| bus_irdy | output | 1 | Master in a data phase |
| bus_last | output | 1 | Current data phase is the last of the burst |
| bus_addr | output | AW | Address of the current or next word |
| bus_trdy | input | 1 | Target completes the data phase |
| bus_rdata | input | DW | Read data |
| tgt_valid | input | 1 | Target access strobe |
| tgt_write | input | 1 | Target access is a write |
| tgt_addr | input | TAW | Target address: top bit selects buffer or scratch |
| tgt_wdata | input | DW | Target write data |
| tgt_ack | output | 1 | Target access acknowledge |
| tgt_rdata | output | DW | Target read data |

## Verification
The bound assertions check the cycle-level bus rules on every cycle:
- the address cycle only follows a grant and is followed at once by a data phase;
- a stall holds the address and a completed non-final phase advances it by one word;
- every burst ends with a request-free cycle;
- single mode always marks the phase as last;
- done lasts one cycle and never overlaps busy.

Only the bench scenarios can show the following:
- burst lengths predicted from the timer value and the grant pattern;
- the exact resume addresses after preemption;
- the buffer contents read back through the target port;
- that target traffic interleaved with suspended transfers leaves the word stream intact.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_SUSPEND,
    ST_DONE
  } bmr_state_e;

endpackage

// File: rtl/bmr_lat_timer.sv
module bmr_lat_timer #(
  parameter int LTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LTW-1:0] cfg_lat,
  input  logic           cfg_single,
  input  logic           load,
  input  logic           dec,
  output logic           expired,
  output logic           single_mode
);

  logic [LTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= cfg_lat;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired     = (cnt_q == '0);
  assign single_mode = cfg_single || (cfg_lat == '0);

endmodule

// File: rtl/bmr_xfer_fsm.sv
module bmr_xfer_fsm
  import bmr_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_valid,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_bytes,
  input  logic          bus_gnt,
  input  logic          bus_trdy,
  input  logic          single_mode,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic          tmr_dec,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  output logic          bus_adv,
  output logic          bus_irdy,
  output logic          bus_last,
  output logic          bus_frame,
  output logic          phase_done,
  output logic [AW-1:0] cur_addr
);

  localparam int STEP = DW / 8;

  bmr_state_e    st_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          final_word;

  assign final_word = (rem_q == CW'(STEP));

  always_comb begin
    bus_last = 1'b0;
    if (st_q == ST_DATA) begin
      bus_last = final_word || single_mode || (tmr_expired && !bus_gnt);
    end
  end

  assign phase_done = (st_q == ST_DATA) && bus_trdy;
  assign bus_req    = (st_q == ST_REQ);
  assign bus_adv    = (st_q == ST_ADDR);
  assign bus_irdy   = (st_q == ST_DATA);
  assign bus_frame  = bus_adv || (bus_irdy && !bus_last);
  assign busy       = (st_q == ST_REQ) || (st_q == ST_ADDR) ||
                      (st_q == ST_DATA) || (st_q == ST_SUSPEND);
  assign done       = (st_q == ST_DONE);
  assign tmr_load   = bus_adv;
  assign tmr_dec    = bus_irdy;
  assign cur_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_valid) begin
            addr_q <= start_addr;
            rem_q  <= start_bytes;
            st_q   <= (start_bytes == '0) ? ST_DONE : ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) st_q <= ST_ADDR;
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: begin
          if (bus_trdy) begin
            addr_q <= addr_q + AW'(STEP);
            rem_q  <= rem_q - CW'(STEP);
            if (bus_last) st_q <= final_word ? ST_DONE : ST_SUSPEND;
          end
        end
        ST_SUSPEND: st_q <= (rem_q != '0) ? ST_REQ : ST_DONE;
        ST_DONE:    st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bmr_buf_ram.sv
module bmr_buf_ram #(
  parameter int DW    = 32,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [IW-1:0] ra,
  output logic [DW-1:0] rq
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/bmr_tgt_regs.sv
module bmr_tgt_regs #(
  parameter int DW   = 32,
  parameter int MIW  = 6,
  parameter int NREG = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_valid,
  input  logic          tgt_write,
  input  logic [MIW:0]  tgt_addr,
  input  logic [DW-1:0] tgt_wdata,
  output logic          tgt_ack,
  output logic [DW-1:0] tgt_rdata,
  output logic          mem_rd_en,
  output logic [MIW-1:0] mem_rd_idx,
  input  logic [DW-1:0] mem_rd_q
);

  logic [DW-1:0]  regs [NREG];
  logic [DW-1:0]  reg_q;
  logic           sel_mem_q;
  logic           ack_q;
  logic [RIW-1:0] ridx;

  assign ridx       = tgt_addr[RIW-1:0];
  assign mem_rd_en  = tgt_valid && !tgt_write && tgt_addr[MIW];
  assign mem_rd_idx = tgt_addr[MIW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      sel_mem_q <= 1'b0;
      reg_q     <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      ack_q <= tgt_valid;
      if (tgt_valid) begin
        sel_mem_q <= tgt_addr[MIW];
        if (!tgt_addr[MIW]) begin
          if (tgt_write) regs[ridx] <= tgt_wdata;
          reg_q <= regs[ridx];
        end
      end
    end
  end

  assign tgt_ack   = ack_q;
  assign tgt_rdata = sel_mem_q ? mem_rd_q : reg_q;

endmodule

// File: rtl/bm_burst_reader.sv
module bm_burst_reader
  import bmr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int DW        = 32,
  parameter int LTW       = 8,
  parameter int MEM_WORDS = 64,
  parameter int NREG      = 4,
  localparam int MIW      = $clog2(MEM_WORDS),
  localparam int TAW      = MIW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LTW-1:0] cfg_lat_timer,
  input  logic           cfg_single_read,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [CW-1:0]  req_bytes,
  output logic           busy,
  output logic           done,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_adv,
  output logic           bus_frame,
  output logic           bus_irdy,
  output logic           bus_last,
  output logic [AW-1:0]  bus_addr,
  input  logic           bus_trdy,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           tgt_valid,
  input  logic           tgt_write,
  input  logic [TAW-1:0] tgt_addr,
  input  logic [DW-1:0]  tgt_wdata,
  output logic           tgt_ack,
  output logic [DW-1:0]  tgt_rdata
);

  localparam int WBL = $clog2(DW / 8);

  logic           tmr_load;
  logic           tmr_dec;
  logic           tmr_expired;
  logic           single_mode;
  logic           phase_done;
  logic           mem_rd_en;
  logic [MIW-1:0] mem_rd_idx;
  logic [DW-1:0]  mem_rd_q;

  bmr_lat_timer #(.LTW(LTW)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .cfg_lat     (cfg_lat_timer),
    .cfg_single  (cfg_single_read),
    .load        (tmr_load),
    .dec         (tmr_dec),
    .expired     (tmr_expired),
    .single_mode (single_mode)
  );

  bmr_xfer_fsm #(.AW(AW), .CW(CW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_valid (req_valid),
    .start_addr  (req_addr),
    .start_bytes (req_bytes),
    .bus_gnt     (bus_gnt),
    .bus_trdy    (bus_trdy),
    .single_mode (single_mode),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_dec     (tmr_dec),
    .busy        (busy),
    .done        (done),
    .bus_req     (bus_req),
    .bus_adv     (bus_adv),
    .bus_irdy    (bus_irdy),
    .bus_last    (bus_last),
    .bus_frame   (bus_frame),
    .phase_done  (phase_done),
    .cur_addr    (bus_addr)
  );

  bmr_buf_ram #(.DW(DW), .WORDS(MEM_WORDS)) u_ram (
    .clk (clk),
    .we  (phase_done),
    .wa  (bus_addr[WBL +: MIW]),
    .wd  (bus_rdata),
    .re  (mem_rd_en),
    .ra  (mem_rd_idx),
    .rq  (mem_rd_q)
  );

  bmr_tgt_regs #(.DW(DW), .MIW(MIW), .NREG(NREG)) u_tgt (
    .clk        (clk),
    .rst        (rst),
    .tgt_valid  (tgt_valid),
    .tgt_write  (tgt_write),
    .tgt_addr   (tgt_addr),
    .tgt_wdata  (tgt_wdata),
    .tgt_ack    (tgt_ack),
    .tgt_rdata  (tgt_rdata),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_idx (mem_rd_idx),
    .mem_rd_q   (mem_rd_q)
  );

endmodule

// File: rtl/bmr_chk.sv
module bmr_chk #(
  parameter int AW  = 32,
  parameter int LTW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [LTW-1:0] cfg_lat_timer,
  input logic           cfg_single_read,
  input logic           busy,
  input logic           done,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           bus_adv,
  input logic           bus_irdy,
  input logic           bus_last,
  input logic           bus_trdy,
  input logic [AW-1:0]  bus_addr
);

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy); // R2

  AST_ADV_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    bus_adv |-> $past(bus_req && bus_gnt)); // R3

  AST_ADV_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    bus_adv |=> (bus_irdy && !bus_adv)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (bus_irdy && !bus_trdy) |=> (bus_irdy && $stable(bus_addr))); // R4

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_irdy && bus_trdy && !bus_last) |=> (bus_irdy && (bus_addr == $past(bus_addr) + AW'(4)))); // R4

  AST_BURST_GAP: assert property (@(posedge clk) disable iff (rst)
    (bus_irdy && bus_trdy && bus_last) |=> (!bus_irdy && !bus_req)); // R6

  AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (bus_irdy && (cfg_single_read || (cfg_lat_timer == '0))) |-> bus_last); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_req)); // R9

endmodule

bind bm_burst_reader bmr_chk #(.AW(AW), .LTW(LTW)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_lat_timer   (cfg_lat_timer),
  .cfg_single_read (cfg_single_read),
  .busy            (busy),
  .done            (done),
  .bus_req         (bus_req),
  .bus_gnt         (bus_gnt),
  .bus_adv         (bus_adv),
  .bus_irdy        (bus_irdy),
  .bus_last        (bus_last),
  .bus_trdy        (bus_trdy),
  .bus_addr        (bus_addr)
);

// File: tb/bm_burst_reader_tb.sv
module bm_burst_reader_tb;

  localparam int AW = 32, CW = 16, DW = 32, LTW = 8, MW = 64, TAW = 7;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic [LTW-1:0] cfg_lat_timer;
  logic           cfg_single_read;
  logic           req_valid;
  logic [AW-1:0]  req_addr;
  logic [CW-1:0]  req_bytes;
  logic           busy, done, bus_req, bus_gnt, bus_adv, bus_frame, bus_irdy, bus_last;
  logic [AW-1:0]  bus_addr;
  logic           bus_trdy;
  logic [DW-1:0]  bus_rdata;
  logic           tgt_valid, tgt_write, tgt_ack;
  logic [TAW-1:0] tgt_addr;
  logic [DW-1:0]  tgt_wdata, tgt_rdata;

  bm_burst_reader u_dut (.*);

  int n_chk = 0, n_err = 0;
  int seed = 1;
  int gmode = 0, tmode = 0;
  int nwords = 0, phases = 0, blen = 0, bleft = 0, done_cnt = 0, cyc = 0;
  logic [AW-1:0] xbase = '0, scur = '0;
  logic pend = 1'b0, fin = 1'b0, req_seen = 1'b0, gap_next = 1'b0;

  function automatic logic [31:0] pat(input logic [31:0] a, input int s);
    return {a[15:0] ^ 16'hC3A5, a[15:0] + s[15:0]};
  endfunction

  assign bus_rdata = pat(scur, seed);

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Bus target and arbiter model plus observation, away from the rising edge
  initial begin
    bus_gnt = 1'b0;
    bus_trdy = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin scur = scur + 32'd4; pend = 1'b0; end
      case (gmode)
        0: bus_gnt = 1'b1;
        1: bus_gnt = bus_req;
        default: bus_gnt = (cyc % 7) < 4;
      endcase
      bus_trdy = (tmode == 0) ? 1'b1 : ((cyc % 3) != 2);
      #1;
      if (!rst) begin
        if (bus_req) req_seen = 1'b1;
        if (gap_next) begin
          chk(!bus_req && busy, "R6", "request gap after preemption", bus_req, 0);
          gap_next = 1'b0;
        end
        if (done) begin
          done_cnt++;
          fin = 1'b1;
          chk(!busy, "R9", "busy low with done", busy, 0);
        end
        if (bus_adv) begin
          chk(bus_addr == xbase + 32'(4 * phases), phases == 0 ? "R3" : "R6",
              "address cycle address", bus_addr, xbase + 32'(4 * phases));
          chk(bus_frame, "R10", "frame in address cycle", bus_frame, 1);
          scur = bus_addr;
          bleft = nwords - phases;
          blen = 0;
        end
        if (bus_irdy && bus_trdy) begin
          chk(bus_addr == xbase + 32'(4 * phases), "R4", "data phase address",
              bus_addr, xbase + 32'(4 * phases));
          chk(bus_frame == !bus_last, "R10", "frame versus last", bus_frame, !bus_last);
          phases++;
          blen++;
          pend = 1'b1;
          if (phases == nwords) chk(bus_last, "R10", "last on final word", bus_last, 1);
          if (bus_last) begin
            if (phases < nwords) gap_next = 1'b1;
            if (tmode == 0 && gmode != 2) begin
              int e;
              if (cfg_single_read || cfg_lat_timer == 0) e = 1;
              else if (gmode == 0) e = bleft;
              else e = (int'(cfg_lat_timer) + 1 < bleft) ? int'(cfg_lat_timer) + 1 : bleft;
              chk(blen == e, (cfg_single_read || cfg_lat_timer == 0) ? "R7" : "R5",
                  "burst length", blen, e);
            end
          end
        end
      end
    end
  end

  task automatic tgt_rw(input logic wr, input logic [TAW-1:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic ack);
    @(negedge clk);
    tgt_valid = 1'b1; tgt_write = wr; tgt_addr = a; tgt_wdata = wd;
    @(negedge clk);
    tgt_valid = 1'b0; tgt_write = 1'b0;
    #1;
    ack = tgt_ack;
    rd = tgt_rdata;
  endtask

  task automatic run_xfer(input int lat, input bit single, input int gm, input int tm,
                          input int words, input int woff);
    logic [31:0] rd, v;
    logic ack;
    int wd;
    @(negedge clk);
    cfg_lat_timer = LTW'(lat); cfg_single_read = single;
    gmode = gm; tmode = tm;
    seed = seed + 7;
    xbase = 32'h0004_0000 + 32'(4 * woff);
    nwords = words; phases = 0; done_cnt = 0; fin = 1'b0; req_seen = 1'b0; gap_next = 1'b0;
    req_valid = 1'b1; req_addr = xbase; req_bytes = CW'(4 * words);
    @(negedge clk);
    // held for a second cycle with a different address: must be ignored
    req_addr = 32'h0008_0100;
    #1;
    chk(busy, "R2", "busy after request", busy, 1);
    @(negedge clk);
    req_valid = 1'b0;
    wd = 0;
    fork
      begin
        while (!fin && wd < 3000) begin @(negedge clk); wd++; end
      end
      begin
        int k = 0;
        while (!fin) begin
          v = pat(32'(k * 13 + seed), k);
          tgt_rw(1'b1, TAW'(k % 4), v, rd, ack);
          chk(ack, "R8", "write acknowledged", ack, 1);
          tgt_rw(1'b0, TAW'(k % 4), 32'h0, rd, ack);
          chk(ack && rd == v, "R8", "scratch readback", rd, v);
          k++;
        end
      end
    join
    chk(fin, "R9", "transfer finished", fin, 1);
    @(negedge clk); @(negedge clk);
    chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    chk(phases == nwords, "R8", "phase count with target traffic", phases, nwords);
    for (int i = 0; i < words; i++) begin
      tgt_rw(1'b0, TAW'((1 << 6) | (woff + i)), 32'h0, rd, ack);
      chk(rd == pat(xbase + 32'(4 * i), seed), "R4", "buffer word", rd,
          pat(xbase + 32'(4 * i), seed));
    end
  endtask

  initial begin
    int lats [5] = '{0, 1, 2, 3, 32};
    int sizes [4] = '{1, 2, 5, 11};
    int n = 0;
    rst = 1'b1;
    cfg_lat_timer = 8'h20; cfg_single_read = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_bytes = '0;
    tgt_valid = 1'b0; tgt_write = 1'b0; tgt_addr = '0; tgt_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !bus_req && !bus_adv && !bus_irdy && !tgt_ack, "R1",
        "outputs in reset", {busy, done, bus_req, bus_adv, bus_irdy, tgt_ack}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!busy && !done && !bus_req, "R1", "idle after reset", {busy, done, bus_req}, 0);

    // zero-length request
    @(negedge clk);
    fin = 1'b0; done_cnt = 0; req_seen = 1'b0; nwords = 0;
    req_valid = 1'b1; req_addr = 32'h100; req_bytes = '0;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(done && !busy, "R9", "zero count gives done", done, 1);
    @(negedge clk); @(negedge clk);
    chk(!req_seen, "R9", "no bus request for zero count", req_seen, 0);

    for (int li = 0; li < 5; li++)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 3; g++)
          for (int t = 0; t < 2; t++)
            for (int z = 0; z < 4; z++) begin
              run_xfer(lats[li], s[0], g, t, sizes[z], n % 8);
              n++;
            end
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    report();
    $finish;
  end

endmodule